// File: doc/BRIEF.md
# Dual-Bank Data Address Generator

This block supplies data memory addresses to a DSP datapath built around two memory banks, a left one and a right one. In every cycle it can present four addresses at once: a left and a right read address (the read path) and a left and a right write address (the store path). The two paths run independently. Each address comes from one of sixteen address registers. The register index picked for a channel stands in for the instruction field that would normally name it.

Each address register has its own pointer, stride, buffer base, buffer length, addressing mode and FFT size. Linear mode emits the pointer and then adds the stride to it. Circular mode keeps the pointer inside a buffer given by base and length, and wraps it when it steps over either end. Bit-reversed mode emits the buffer base plus the bit-reversed low bits of an index pointer, which puts FFT data into the right order. A simple configuration port loads any field of any register. A comparator checks the pointer of a chosen register against a loop end value so that the sequencer can detect when a loop has finished.

Addresses are combinational from the current register state. Pointers are post-updated at the clock edge when the channel that uses them is enabled.

Top module: `dual_bank_agu`

## Requirements
- R1: After reset every pointer, stride, base, length, mode and FFT size is zero, so every channel emits address 0.
- R2: When cfg_we_i is high, cfg_data_i is written at the next clock edge into the field of register cfg_idx_i chosen by cfg_field_i: 0 pointer, 1 stride, 2 base, 3 length, 4 mode (data bits 1:0), 5 FFT size (data bits 3:0). Field codes 6 and 7 change nothing.
- R3: In linear mode (mode 0) a channel emits the pointer. When the channel is enabled, the pointer becomes pointer plus stride modulo 8192, and the stride is read as 13-bit two's complement.
- R4: In circular mode (mode 1) the address is the pointer. When the channel is enabled, the pointer plus stride is first formed as a sum. If that sum is at or above base plus length, the new pointer is the sum minus length. If the sum is below base, the new pointer is the sum plus length. Otherwise the new pointer is the sum.
- R5: In bit-reversed mode (mode 2) the address is base plus the low n bits of the pointer in reversed order. Here n is the FFT size field, with 0 treated as 1 and values above 12 treated as 12. When the channel is enabled, the pointer becomes (pointer plus stride) modulo 2^n.
- R6: The four channels (read left, read right, store left, store right) each take their own enable and register index. All four addresses are valid in the same cycle, and all four pointers update at the same edge.
- R7: When several enabled channels select the same register, they all emit the same address and the pointer advances only once. The channel that sets the new pointer is chosen in the priority order read left, read right, store left, store right.
- R8: A configuration write to a pointer takes priority over a post-update of that same pointer in the same cycle.
- R9: loop_done_o is high in the same cycle whenever the pointer of register loop_idx_i equals loop_end_i.
- R10: A disabled channel leaves its pointer unchanged. Mode value 3 behaves as linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Register index for the configuration write |
| cfg_field_i | input | 3 | Field code for the configuration write |
| cfg_data_i | input | 13 | Configuration write data |
| rd_en_l_i | input | 1 | Read-left channel enable (post-update) |
| rd_sel_l_i | input | 4 | Read-left register index |
| rd_en_r_i | input | 1 | Read-right channel enable |
| rd_sel_r_i | input | 4 | Read-right register index |
| st_en_l_i | input | 1 | Store-left channel enable |
| st_sel_l_i | input | 4 | Store-left register index |
| st_en_r_i | input | 1 | Store-right channel enable |
| st_sel_r_i | input | 4 | Store-right register index |
| loop_idx_i | input | 4 | Register compared against the loop end |
| loop_end_i | input | 13 | Loop end value |
| rd_addr_l_o | output | 13 | Left bank read address |
| rd_addr_r_o | output | 13 | Right bank read address |
| st_addr_l_o | output | 13 | Left bank write address |
| st_addr_r_o | output | 13 | Right bank write address |
| loop_done_o | output | 1 | Loop end reached |

## Verification
Linear stepping is tried with a positive stride and with a negative stride that crosses address zero. This shows whether the stride is treated as signed and whether the pointer wraps modulo the address space. Circular buffers are stepped over the top end and under the bottom end, which shows whether the overshoot is kept or clamped. Bit-reversed runs use index values whose reversal differs from the index, an index that wraps to zero, and the two FFT size clamp cases. Some tests use four distinct registers in parallel and others make several channels collide on one register. Together these show independent updates apart from one single shared update, and a configuration write in the same cycle shows whether host priority holds.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_BREV = 2'd2,
    MODE_LIN3 = 2'd3
  } agu_mode_e;

  typedef enum logic [2:0] {
    FLD_PTR    = 3'd0,
    FLD_STRIDE = 3'd1,
    FLD_BASE   = 3'd2,
    FLD_LEN    = 3'd3,
    FLD_MODE   = 3'd4,
    FLD_FFTLG  = 3'd5
  } cfg_field_e;

  // channel order doubles as update priority (lowest index wins)
  localparam int CH_RD_L = 0;
  localparam int CH_RD_R = 1;
  localparam int CH_ST_L = 2;
  localparam int CH_ST_R = 3;
  localparam int NUM_CH  = 4;
endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int AW     = 13,
  parameter int LG_MAX = 12,
  parameter int LGW    = 4
) (
  input  logic [AW-1:0]  ptr_i,
  input  logic [AW-1:0]  stride_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  len_i,
  input  logic [1:0]     mode_i,
  input  logic [LGW-1:0] fftlg_i,
  output logic [AW-1:0]  addr_o,
  output logic [AW-1:0]  nxt_o
);
  localparam int SW = AW + 2;

  logic signed [SW-1:0] sum_s, top_s, base_s, len_s, wrap_s;
  logic [AW-1:0] lin_sum, rev_idx, brev_mask;
  int unsigned   nbits;

  always_comb begin
    lin_sum = ptr_i + stride_i;
    sum_s   = $signed({2'b00, ptr_i}) + $signed({{2{stride_i[AW-1]}}, stride_i});
    base_s  = $signed({2'b00, base_i});
    len_s   = $signed({2'b00, len_i});
    top_s   = base_s + len_s;
    if (sum_s >= top_s)       wrap_s = sum_s - len_s;
    else if (sum_s < base_s)  wrap_s = sum_s + len_s;
    else                      wrap_s = sum_s;
  end

  always_comb begin
    if (fftlg_i == '0)                       nbits = 1;
    else if (int'(fftlg_i) > LG_MAX)         nbits = LG_MAX;
    else                                     nbits = int'(fftlg_i);
    rev_idx   = '0;
    brev_mask = '0;
    for (int i = 0; i < LG_MAX; i++) begin
      if (i < int'(nbits)) begin
        rev_idx[i]   = ptr_i[int'(nbits) - 1 - i];
        brev_mask[i] = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (agu_mode_e'(mode_i))
      MODE_CIRC: begin
        addr_o = ptr_i;
        nxt_o  = wrap_s[AW-1:0];
      end
      MODE_BREV: begin
        addr_o = base_i + rev_idx;
        nxt_o  = lin_sum & brev_mask;
      end
      default: begin
        addr_o = ptr_i;
        nxt_o  = lin_sum;
      end
    endcase
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int AW   = 13,
  parameter int NREG = 16,
  parameter int LGW  = 4,
  parameter int NCH  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [IW-1:0]                 cfg_idx_i,
  input  logic [2:0]                    cfg_field_i,
  input  logic [AW-1:0]                 cfg_data_i,
  input  logic [NCH-1:0]                ch_en_i,
  input  logic [NCH-1:0][IW-1:0]        ch_idx_i,
  input  logic [NCH-1:0][AW-1:0]        ch_nxt_i,
  output logic [NREG-1:0][AW-1:0]       ptr_o,
  output logic [NREG-1:0][AW-1:0]       stride_o,
  output logic [NREG-1:0][AW-1:0]       base_o,
  output logic [NREG-1:0][AW-1:0]       len_o,
  output logic [NREG-1:0][1:0]          mode_o,
  output logic [NREG-1:0][LGW-1:0]      fftlg_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          upd_hit, cfg_hit;
    logic [AW-1:0] upd_val;

    always_comb begin
      upd_hit = 1'b0;
      upd_val = ptr_o[r];
      for (int c = NCH - 1; c >= 0; c--) begin
        if (ch_en_i[c] && (ch_idx_i[c] == IW'(r))) begin
          upd_hit = 1'b1;
          upd_val = ch_nxt_i[c];
        end
      end
    end

    assign cfg_hit = cfg_we_i && (cfg_idx_i == IW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[r]    <= '0;
        stride_o[r] <= '0;
        base_o[r]   <= '0;
        len_o[r]    <= '0;
        mode_o[r]   <= '0;
        fftlg_o[r]  <= '0;
      end else begin
        if (cfg_hit && cfg_field_i == FLD_PTR) ptr_o[r] <= cfg_data_i;
        else if (upd_hit)                      ptr_o[r] <= upd_val;
        if (cfg_hit) begin
          case (cfg_field_e'(cfg_field_i))
            FLD_STRIDE: stride_o[r] <= cfg_data_i;
            FLD_BASE:   base_o[r]   <= cfg_data_i;
            FLD_LEN:    len_o[r]    <= cfg_data_i;
            FLD_MODE:   mode_o[r]   <= cfg_data_i[1:0];
            FLD_FFTLG:  fftlg_o[r]  <= cfg_data_i[LGW-1:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/agu_loop_cmp.sv
module agu_loop_cmp #(
  parameter int AW   = 13,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][AW-1:0] ptr_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [AW-1:0]           end_i,
  output logic                    done_o
);
  assign done_o = (ptr_i[idx_i] == end_i);
endmodule

// File: rtl/dual_bank_agu.sv
module dual_bank_agu
  import agu_pkg::*;
#(
  parameter int AW     = 13,
  parameter int NREG   = 16,
  parameter int LG_MAX = 12,
  localparam int IW    = $clog2(NREG),
  localparam int LGW   = $clog2(LG_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [2:0]    cfg_field_i,
  input  logic [AW-1:0] cfg_data_i,
  input  logic          rd_en_l_i,
  input  logic [IW-1:0] rd_sel_l_i,
  input  logic          rd_en_r_i,
  input  logic [IW-1:0] rd_sel_r_i,
  input  logic          st_en_l_i,
  input  logic [IW-1:0] st_sel_l_i,
  input  logic          st_en_r_i,
  input  logic [IW-1:0] st_sel_r_i,
  input  logic [IW-1:0] loop_idx_i,
  input  logic [AW-1:0] loop_end_i,
  output logic [AW-1:0] rd_addr_l_o,
  output logic [AW-1:0] rd_addr_r_o,
  output logic [AW-1:0] st_addr_l_o,
  output logic [AW-1:0] st_addr_r_o,
  output logic          loop_done_o
);
  logic [NREG-1:0][AW-1:0]  ptr_vec, stride_vec, base_vec, len_vec;
  logic [NREG-1:0][1:0]     mode_vec;
  logic [NREG-1:0][LGW-1:0] fftlg_vec;

  logic [NUM_CH-1:0]         ch_en;
  logic [NUM_CH-1:0][IW-1:0] ch_idx;
  logic [NUM_CH-1:0][AW-1:0] ch_addr, ch_nxt;

  assign ch_en[CH_RD_L]  = rd_en_l_i;
  assign ch_en[CH_RD_R]  = rd_en_r_i;
  assign ch_en[CH_ST_L]  = st_en_l_i;
  assign ch_en[CH_ST_R]  = st_en_r_i;
  assign ch_idx[CH_RD_L] = rd_sel_l_i;
  assign ch_idx[CH_RD_R] = rd_sel_r_i;
  assign ch_idx[CH_ST_L] = st_sel_l_i;
  assign ch_idx[CH_ST_R] = st_sel_r_i;

  agu_regfile #(.AW(AW), .NREG(NREG), .LGW(LGW), .NCH(NUM_CH)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_field_i, .cfg_data_i,
    .ch_en_i  (ch_en),
    .ch_idx_i (ch_idx),
    .ch_nxt_i (ch_nxt),
    .ptr_o    (ptr_vec),
    .stride_o (stride_vec),
    .base_o   (base_vec),
    .len_o    (len_vec),
    .mode_o   (mode_vec),
    .fftlg_o  (fftlg_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    agu_addr_calc #(.AW(AW), .LG_MAX(LG_MAX), .LGW(LGW)) u_calc (
      .ptr_i    (ptr_vec[ch_idx[c]]),
      .stride_i (stride_vec[ch_idx[c]]),
      .base_i   (base_vec[ch_idx[c]]),
      .len_i    (len_vec[ch_idx[c]]),
      .mode_i   (mode_vec[ch_idx[c]]),
      .fftlg_i  (fftlg_vec[ch_idx[c]]),
      .addr_o   (ch_addr[c]),
      .nxt_o    (ch_nxt[c])
    );
  end

  assign rd_addr_l_o = ch_addr[CH_RD_L];
  assign rd_addr_r_o = ch_addr[CH_RD_R];
  assign st_addr_l_o = ch_addr[CH_ST_L];
  assign st_addr_r_o = ch_addr[CH_ST_R];

  agu_loop_cmp #(.AW(AW), .NREG(NREG)) u_loop (
    .ptr_i  (ptr_vec),
    .idx_i  (loop_idx_i),
    .end_i  (loop_end_i),
    .done_o (loop_done_o)
  );
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int AW     = 13,
  parameter int NREG   = 16,
  parameter int LG_MAX = 12,
  localparam int IW    = $clog2(NREG),
  localparam int LGW   = $clog2(LG_MAX + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic [IW-1:0]            cfg_idx_i,
  input logic [2:0]               cfg_field_i,
  input logic [AW-1:0]            cfg_data_i,
  input logic                     rd_en_l_i,
  input logic [IW-1:0]            rd_sel_l_i,
  input logic                     rd_en_r_i,
  input logic                     st_en_l_i,
  input logic                     st_en_r_i,
  input logic [AW-1:0]            rd_addr_l_o,
  input logic [NREG-1:0][AW-1:0]  ptr_vec,
  input logic [NREG-1:0][AW-1:0]  stride_vec,
  input logic [NREG-1:0][AW-1:0]  base_vec,
  input logic [NREG-1:0][1:0]     mode_vec,
  input logic [NREG-1:0][LGW-1:0] fftlg_vec
);
  logic [AW-1:0] brev_off;
  logic          sel_linear;
  assign brev_off   = rd_addr_l_o - base_vec[rd_sel_l_i];
  assign sel_linear = (mode_vec[rd_sel_l_i] == MODE_LIN) || (mode_vec[rd_sel_l_i] == MODE_LIN3);

  p_host_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_field_i == FLD_PTR) |=> ptr_vec[$past(cfg_idx_i)] == $past(cfg_data_i));

  p_linear_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_l_i && !cfg_we_i && sel_linear) |=>
      ptr_vec[$past(rd_sel_l_i)] == $past(ptr_vec[rd_sel_l_i] + stride_vec[rd_sel_l_i]));

  p_brev_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_vec[rd_sel_l_i] == MODE_BREV && fftlg_vec[rd_sel_l_i] != '0 &&
     int'(fftlg_vec[rd_sel_l_i]) <= LG_MAX) |-> (brev_off >> fftlg_vec[rd_sel_l_i]) == '0);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !rd_en_l_i && !rd_en_r_i && !st_en_l_i && !st_en_r_i) |=> $stable(ptr_vec));
endmodule

bind dual_bank_agu agu_checker #(.AW(AW), .NREG(NREG), .LG_MAX(LG_MAX)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_field_i, .cfg_data_i,
  .rd_en_l_i, .rd_sel_l_i, .rd_en_r_i, .st_en_l_i, .st_en_r_i, .rd_addr_l_o,
  .ptr_vec, .stride_vec, .base_vec, .mode_vec, .fftlg_vec
);

// File: tb/test_dual_bank_agu.sv
`timescale 1ns/1ps
module test_dual_bank_agu;
  localparam int CLK_NS = 20;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [2:0]  cfg_field = 0;
  logic [12:0] cfg_data = 0;
  logic        rd_en_l = 0, rd_en_r = 0, st_en_l = 0, st_en_r = 0;
  logic [3:0]  rd_sel_l = 0, rd_sel_r = 0, st_sel_l = 0, st_sel_r = 0;
  logic [3:0]  loop_idx = 0;
  logic [12:0] loop_end = 0;
  logic [12:0] rd_addr_l, rd_addr_r, st_addr_l, st_addr_r;
  logic        loop_done;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_bank_agu i_dual_bank_agu (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_field_i(cfg_field), .cfg_data_i(cfg_data),
    .rd_en_l_i(rd_en_l), .rd_sel_l_i(rd_sel_l), .rd_en_r_i(rd_en_r), .rd_sel_r_i(rd_sel_r),
    .st_en_l_i(st_en_l), .st_sel_l_i(st_sel_l), .st_en_r_i(st_en_r), .st_sel_r_i(st_sel_r),
    .loop_idx_i(loop_idx), .loop_end_i(loop_end),
    .rd_addr_l_o(rd_addr_l), .rd_addr_r_o(rd_addr_r),
    .st_addr_l_o(st_addr_l), .st_addr_r_o(st_addr_r),
    .loop_done_o(loop_done)
  );

  task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    rd_en_l = 0; rd_en_r = 0; st_en_l = 0; st_en_r = 0;
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [2:0] fld, input logic [12:0] d);
    @(negedge clk);
    idle_all();
    cfg_we = 1; cfg_idx = idx; cfg_field = fld; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // view a register's address on read-left without updating it
  task automatic peek(input logic [3:0] idx, input logic [12:0] exp, input string tag);
    @(negedge clk);
    idle_all();
    rd_sel_l = idx;
    #1 chk(tag, rd_addr_l, exp);
  endtask

  // one enabled access on channel ch (0 rd_l, 1 rd_r, 2 st_l, 3 st_r)
  task automatic pulse(input int ch, input logic [3:0] idx, input logic [12:0] exp, input string tag);
    @(negedge clk);
    idle_all();
    case (ch)
      0: begin rd_en_l = 1; rd_sel_l = idx; end
      1: begin rd_en_r = 1; rd_sel_r = idx; end
      2: begin st_en_l = 1; st_sel_l = idx; end
      default: begin st_en_r = 1; st_sel_r = idx; end
    endcase
    #1;
    case (ch)
      0: chk(tag, rd_addr_l, exp);
      1: chk(tag, rd_addr_r, exp);
      2: chk(tag, st_addr_l, exp);
      default: chk(tag, st_addr_r, exp);
    endcase
    @(negedge clk);
    idle_all();
  endtask

  task automatic t_reset();
    peek(4'd0, 13'd0, "R1 reset reg0 address");
    peek(4'd9, 13'd0, "R1 reset reg9 address");
    loop_idx = 4'd0; loop_end = 13'd0;
    #1 chk("R1 reset loop flag", {12'd0, loop_done}, 13'd1);
  endtask

  task automatic t_host_write();
    cfg(4'd3, 3'd0, 13'h123);
    peek(4'd3, 13'h123, "R2 pointer write");
    cfg(4'd3, 3'd6, 13'h0AA);
    cfg(4'd3, 3'd7, 13'h055);
    peek(4'd3, 13'h123, "R2 unused field codes ignored");
    cfg(4'd3, 3'd2, 13'h040);
    cfg(4'd3, 3'd4, 13'd2);
    cfg(4'd3, 3'd5, 13'd2);
    peek(4'd3, 13'h040 + 13'd3, "R2 base/mode/size fields written");
  endtask

  task automatic t_linear();
    cfg(4'd1, 3'd0, 13'd10);
    cfg(4'd1, 3'd1, 13'd3);
    pulse(0, 4'd1, 13'd10, "R3 linear first");
    pulse(0, 4'd1, 13'd13, "R3 linear second");
    peek(4'd1, 13'd16, "R3 linear after two");
    cfg(4'd2, 3'd0, 13'd1);
    cfg(4'd2, 3'd1, 13'h1FFE);
    pulse(1, 4'd2, 13'd1, "R3 negative stride emit");
    peek(4'd2, 13'h1FFF, "R3 negative stride wraps modulo 8192");
  endtask

  task automatic t_circular();
    cfg(4'd4, 3'd2, 13'd100);
    cfg(4'd4, 3'd3, 13'd10);
    cfg(4'd4, 3'd4, 13'd1);
    cfg(4'd4, 3'd0, 13'd107);
    cfg(4'd4, 3'd1, 13'd4);
    pulse(2, 4'd4, 13'd107, "R4 circular emit");
    peek(4'd4, 13'd101, "R4 wrap over top keeps overshoot");
    cfg(4'd4, 3'd1, 13'h1FFD);
    pulse(2, 4'd4, 13'd101, "R4 circular emit low");
    peek(4'd4, 13'd108, "R4 wrap under base");
    cfg(4'd4, 3'd1, 13'd2);
    pulse(3, 4'd4, 13'd108, "R4 inside step emit");
    peek(4'd4, 13'd100, "R4 step to exact top wraps to base");
  endtask

  task automatic t_bitrev();
    cfg(4'd5, 3'd2, 13'h200);
    cfg(4'd5, 3'd5, 13'd3);
    cfg(4'd5, 3'd4, 13'd2);
    cfg(4'd5, 3'd1, 13'd1);
    cfg(4'd5, 3'd0, 13'd1);
    pulse(3, 4'd5, 13'h204, "R5 reverse of 1");
    pulse(3, 4'd5, 13'h202, "R5 reverse of 2");
    cfg(4'd5, 3'd0, 13'd6);
    pulse(3, 4'd5, 13'h203, "R5 reverse of 6");
    pulse(3, 4'd5, 13'h207, "R5 reverse of 7");
    peek(4'd5, 13'h200, "R5 index wraps modulo 2^n");
    cfg(4'd6, 3'd4, 13'd2);
    cfg(4'd6, 3'd1, 13'd1);
    cfg(4'd6, 3'd0, 13'd1);
    pulse(0, 4'd6, 13'd1, "R5 size 0 treated as 1");
    peek(4'd6, 13'd0, "R5 size 0 index mask");
    cfg(4'd7, 3'd4, 13'd2);
    cfg(4'd7, 3'd5, 13'd15);
    cfg(4'd7, 3'd0, 13'd1);
    peek(4'd7, 13'h800, "R5 size above 12 clamped");
  endtask

  task automatic t_parallel();
    for (int k = 0; k < 4; k++) begin
      cfg(4'(8 + k), 3'd0, 13'(16 * (k + 1)));
      cfg(4'(8 + k), 3'd1, 13'(k + 1));
    end
    @(negedge clk);
    rd_en_l = 1; rd_sel_l = 4'd8;
    rd_en_r = 1; rd_sel_r = 4'd9;
    st_en_l = 1; st_sel_l = 4'd10;
    st_en_r = 1; st_sel_r = 4'd11;
    #1;
    chk("R6 read left", rd_addr_l, 13'd16);
    chk("R6 read right", rd_addr_r, 13'd32);
    chk("R6 store left", st_addr_l, 13'd48);
    chk("R6 store right", st_addr_r, 13'd64);
    @(negedge clk);
    idle_all();
    #1;
    chk("R6 read left updated", rd_addr_l, 13'd17);
    chk("R6 read right updated", rd_addr_r, 13'd34);
    chk("R6 store left updated", st_addr_l, 13'd51);
    chk("R6 store right updated", st_addr_r, 13'd68);
  endtask

  task automatic t_collision();
    cfg(4'd12, 3'd0, 13'd40);
    cfg(4'd12, 3'd1, 13'd5);
    @(negedge clk);
    rd_en_r = 1; rd_sel_r = 4'd12;
    st_en_l = 1; st_sel_l = 4'd12;
    st_en_r = 1; st_sel_r = 4'd12;
    #1;
    chk("R7 shared address rd_r", rd_addr_r, 13'd40);
    chk("R7 shared address st_l", st_addr_l, 13'd40);
    chk("R7 shared address st_r", st_addr_r, 13'd40);
    @(negedge clk);
    idle_all();
    peek(4'd12, 13'd45, "R7 single advance");
  endtask

  task automatic t_host_wins();
    cfg(4'd13, 3'd0, 13'd50);
    cfg(4'd13, 3'd1, 13'd1);
    @(negedge clk);
    rd_en_l = 1; rd_sel_l = 4'd13;
    st_en_r = 1; st_sel_r = 4'd13;
    cfg_we = 1; cfg_idx = 4'd13; cfg_field = 3'd0; cfg_data = 13'd200;
    @(negedge clk);
    cfg_we = 0; idle_all();
    peek(4'd13, 13'd200, "R8 host write beats post-update");
  endtask

  task automatic t_loop();
    cfg(4'd14, 3'd0, 13'd7);
    cfg(4'd14, 3'd1, 13'd1);
    @(negedge clk);
    loop_idx = 4'd14; loop_end = 13'd7;
    #1 chk("R9 loop end match", {12'd0, loop_done}, 13'd1);
    loop_end = 13'd8;
    #1 chk("R9 loop end mismatch", {12'd0, loop_done}, 13'd0);
    pulse(0, 4'd14, 13'd7, "R9 step pointer");
    #1 chk("R9 loop end reached after step", {12'd0, loop_done}, 13'd1);
  endtask

  task automatic t_disabled();
    cfg(4'd15, 3'd0, 13'd30);
    cfg(4'd15, 3'd1, 13'd2);
    cfg(4'd15, 3'd4, 13'd3);
    peek(4'd15, 13'd30, "R10 disabled first look");
    peek(4'd15, 13'd30, "R10 disabled holds");
    pulse(2, 4'd15, 13'd30, "R10 mode 3 emit");
    peek(4'd15, 13'd32, "R10 mode 3 steps linearly");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_host_write();
    t_linear();
    t_circular();
    t_bitrev();
    t_parallel();
    t_collision();
    t_host_wins();
    t_loop();
    t_disabled();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule